// File: doc/BRIEF.md
# Grouped Data Bus Inversion Codec

This block cuts switching activity on a wide, multi-pumped data bus. Each bus clock the transmit side takes four 64-bit transfers, packed into one 256-bit word. It splits every transfer into four 16-bit lanes. A lane is sent inverted whenever sending it as-is would flip more than half of its lines compared with what that lane last carried on the wire. A per-lane flag tells the far end that the lane was inverted. The comparison runs from each transfer to the next, including from the last transfer of one clock to the first transfer of the next.

The encoder registers its result, so the bus value and flags appear one clock after the word is accepted. The data lines and flags are active low on the wire. When no word is offered, the bus keeps driving what it drove last and the comparison reference stays as it was. The receive side is a purely combinational decoder. It removes the wire polarity and uses each lane's flag to restore the true data.

Top module: `dbi_codec`

## Requirements
- R1: Transfer k (k = 0..3) occupies bits [64k+63:64k] of the 256-bit word, and transfer 0 goes out first. Within a transfer, lane g (g = 0..3) is bits [16g+15:16g], and its flag is bit 4k+g of the 16-bit flag bus.
- R2: A lane is inverted, and its flag raised, exactly when more than 8 of its 16 lines would otherwise differ from the reference. Exactly 8 differences leaves the lane uninverted.
- R3: On the wire, a logical 1 on a data line or flag is driven low. The wire value is the bitwise complement of the logical value.
- R4: The reference for transfer k>0 is transfer k-1 of the same word as driven. The reference for transfer 0 is transfer 3 of the previously accepted word as driven.
- R5: During and after reset, all data lines and flags are high (deasserted), `bus_valid` is low, and the reference is logical zero on every line.
- R6: A word accepted with `tx_valid` high appears on `bus_data_n`/`bus_inv_n` one clock later, with `bus_valid` high for that one clock.
- R7: When `tx_valid` is low, `bus_valid` goes low the next clock, the bus and flags hold their values, and the reference is not changed.
- R8: The decoder is combinational: `rx_data` equals the lane-wise complement of `rx_data_n`, with each lane complemented once more where its flag on `rx_inv_n` is low.
- R9: Between any two consecutive transfers on the wire, no lane changes more than 8 of its 16 data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | A word is offered this clock |
| tx_data | input | 256 | Four transfers of true data, transfer 0 in the low 64 bits |
| bus_valid | output | 1 | The bus carries a newly encoded word this clock |
| bus_data_n | output | 256 | Encoded data for four transfers, active low |
| bus_inv_n | output | 16 | Per-lane inversion flags, active low |
| rx_data_n | input | 256 | Received wire data, active low |
| rx_inv_n | input | 16 | Received inversion flags, active low |
| rx_data | output | 256 | Recovered true data |

## Verification
The encoded bus value, the flags and `bus_valid` are due one clock after the word is offered. The bench drives each word on a falling edge and samples the outputs on the following falling edge, with exactly one rising edge in between. The bench feeds the encoder outputs straight back into the decoder. Because the decoder is combinational, the recovered data is due in that same sampling slot and is compared there with the word just sent. The hold behaviour is checked at the sample one clock after an idle cycle, and a word sent afterwards confirms that the reference was left unchanged.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int unsigned MAX_LANE = 64;

    function automatic int unsigned ones(input logic [MAX_LANE-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < MAX_LANE; i++) begin
            n += {31'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc #(
    parameter int unsigned GW = 16
) (
    input  logic [GW-1:0] ref_i,
    input  logic [GW-1:0] data_i,
    output logic [GW-1:0] enc_o,
    output logic          inv_o
);
    localparam int unsigned HALF = GW / 2;

    int unsigned flips;

    always_comb begin
        flips = dbi_pkg::ones(dbi_pkg::MAX_LANE'(ref_i ^ data_i));
        inv_o = (flips > HALF);
        enc_o = inv_o ? ~data_i : data_i;
    end
endmodule

// File: rtl/dbi_enc_core.sv
module dbi_enc_core #(
    parameter int unsigned DW    = 64,
    parameter int unsigned GW    = 16,
    parameter int unsigned BEATS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [BEATS*DW-1:0]    in_data,
    output logic                   out_valid,
    output logic [BEATS*DW-1:0]    out_bus_n,
    output logic [BEATS*DW/GW-1:0] out_inv_n
);
    localparam int unsigned NG   = DW / GW;
    localparam int unsigned BW   = BEATS * DW;
    localparam int unsigned FW   = BEATS * NG;
    localparam int unsigned HALF = GW / 2;

    typedef struct packed {
        logic [BW-1:0] bus;
        logic [FW-1:0] inv;
        logic          valid;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic [DW-1:0] ref_chain [0:BEATS];
    logic [BW-1:0] enc_all;
    logic [FW-1:0] inv_all;

    assign ref_chain[0] = st_q.bus[(BEATS-1)*DW +: DW];

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        for (genvar g = 0; g < NG; g++) begin : g_lane
            dbi_lane_enc #(.GW(GW)) u_lane (
                .ref_i  (ref_chain[b][g*GW +: GW]),
                .data_i (in_data[b*DW + g*GW +: GW]),
                .enc_o  (enc_all[b*DW + g*GW +: GW]),
                .inv_o  (inv_all[b*NG + g])
            );
        end
        assign ref_chain[b+1] = enc_all[b*DW +: DW];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.bus = enc_all;
            st_d.inv = inv_all;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_bus_n = ~st_q.bus;
    assign out_inv_n = ~st_q.inv;

    // R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_bus_n) && $stable(out_inv_n)));

    for (genvar g = 0; g < NG; g++) begin : g_chk
        // R9
        beat0_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> dbi_pkg::ones(dbi_pkg::MAX_LANE'(out_bus_n[g*GW +: GW]
                ^ $past(out_bus_n[(BEATS-1)*DW + g*GW +: GW]))) <= HALF);
        for (genvar b = 1; b < BEATS; b++) begin : g_beat_chk
            // R9
            beat_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> dbi_pkg::ones(dbi_pkg::MAX_LANE'(out_bus_n[b*DW + g*GW +: GW]
                    ^ out_bus_n[(b-1)*DW + g*GW +: GW])) <= HALF);
        end
    end
endmodule

// File: rtl/dbi_dec.sv
module dbi_dec #(
    parameter int unsigned DW    = 64,
    parameter int unsigned GW    = 16,
    parameter int unsigned BEATS = 4
) (
    input  logic [BEATS*DW-1:0]    bus_n_i,
    input  logic [BEATS*DW/GW-1:0] inv_n_i,
    output logic [BEATS*DW-1:0]    data_o
);
    localparam int unsigned NG = DW / GW;

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        for (genvar g = 0; g < NG; g++) begin : g_lane
            assign data_o[b*DW + g*GW +: GW] =
                ~bus_n_i[b*DW + g*GW +: GW] ^ {GW{~inv_n_i[b*NG + g]}};
        end
    end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec #(
    parameter int unsigned DW    = 64,
    parameter int unsigned GW    = 16,
    parameter int unsigned BEATS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_valid,
    input  logic [BEATS*DW-1:0]    tx_data,
    output logic                   bus_valid,
    output logic [BEATS*DW-1:0]    bus_data_n,
    output logic [BEATS*DW/GW-1:0] bus_inv_n,
    input  logic [BEATS*DW-1:0]    rx_data_n,
    input  logic [BEATS*DW/GW-1:0] rx_inv_n,
    output logic [BEATS*DW-1:0]    rx_data
);
    dbi_enc_core #(.DW(DW), .GW(GW), .BEATS(BEATS)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_data   (tx_data),
        .out_valid (bus_valid),
        .out_bus_n (bus_data_n),
        .out_inv_n (bus_inv_n)
    );

    dbi_dec #(.DW(DW), .GW(GW), .BEATS(BEATS)) u_dec (
        .bus_n_i (rx_data_n),
        .inv_n_i (rx_inv_n),
        .data_o  (rx_data)
    );
endmodule

// File: tb/test_dbi_codec.sv
module test_dbi_codec;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 2;

    typedef struct packed {
        logic [255:0] data;
        logic [15:0]  flags;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{ {64'hFFFF_FF00_01FF_FFFF, 64'h0000_00FF_FE00_0000,
            64'hFFFF_00FF_01FF_0000, 64'h0000_0000_0000_0000}, 16'hF0A0 },
        '{ {64'hFFFF_00FF_FE00_01FF, 64'h0001_00FF_FE00_FE00,
            64'h0001_00FF_FE00_01FF, 64'h0001_00FF_FE00_00FF}, 16'h8100 }
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_valid = 1'b0;
    logic [255:0] tx_data = '0;
    logic         bus_valid;
    logic [255:0] bus_data_n;
    logic [15:0]  bus_inv_n;
    logic [255:0] rx_data;

    int           checks = 0;
    int           fails = 0;
    logic [63:0]  mref = '0;
    logic [63:0]  last_wire = '1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbi_codec i_dbi_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .bus_valid  (bus_valid),
        .bus_data_n (bus_data_n),
        .bus_inv_n  (bus_inv_n),
        .rx_data_n  (bus_data_n),
        .rx_inv_n   (bus_inv_n),
        .rx_data    (rx_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int cnt16(input logic [15:0] v);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(v[i]);
        return n;
    endfunction

    // Reference model built from R1, R2, R3, R4
    task automatic model(input logic [255:0] d, output logic [255:0] wire_n,
                         output logic [15:0] flag_n);
        logic [255:0] enc;
        logic [15:0]  fl;
        for (int b = 0; b < 4; b++) begin
            for (int g = 0; g < 4; g++) begin
                logic [15:0] lane;
                lane = d[b*64 + g*16 +: 16];
                fl[b*4 + g] = (cnt16(lane ^ mref[g*16 +: 16]) > 8);
                if (fl[b*4 + g]) lane = ~lane;
                enc[b*64 + g*16 +: 16] = lane;
                mref[g*16 +: 16] = lane;
            end
        end
        wire_n = ~enc;
        flag_n = ~fl;
    endtask

    task automatic send(input logic [255:0] d);
        logic [255:0] ew;
        logic [15:0]  ef;
        int           worst;
        logic [63:0]  prev;
        model(d, ew, ef);
        tx_valid = 1'b1;
        tx_data  = d;
        @(negedge clk);
        chk(bus_valid === 1'b1, "R6 bus_valid", {255'd0, bus_valid}, 256'd1);
        chk(bus_data_n === ew, "R2 R4 R3 bus_data_n", bus_data_n, ew);
        chk(bus_inv_n === ef, "R1 R2 R3 bus_inv_n", {240'd0, bus_inv_n}, {240'd0, ef});
        chk(rx_data === d, "R8 rx_data", rx_data, d);
        worst = 0;
        prev = last_wire;
        for (int b = 0; b < 4; b++) begin
            for (int g = 0; g < 4; g++) begin
                int t;
                t = cnt16(bus_data_n[b*64 + g*16 +: 16] ^ prev[g*16 +: 16]);
                if (t > worst) worst = t;
            end
            prev = bus_data_n[b*64 +: 64];
        end
        last_wire = prev;
        chk(worst <= 8, "R9 lane toggles", 256'(worst), 256'd8);
    endtask

    task automatic check_reset();
        chk(bus_data_n === '1, "R5 bus_data_n", bus_data_n, '1);
        chk(bus_inv_n === '1, "R5 bus_inv_n", {240'd0, bus_inv_n}, {240'd0, 16'hFFFF});
        chk(bus_valid === 1'b0, "R5 bus_valid", {255'd0, bus_valid}, 256'd0);
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();

        // R2 R4: hand-worked vectors, including exactly 8 and 9 differences
        for (int i = 0; i < NVEC; i++) begin
            send(VECS[i].data);
            chk(~bus_inv_n === VECS[i].flags, "R2 table flags",
                {240'd0, ~bus_inv_n}, {240'd0, VECS[i].flags});
        end

        // R7: idle cycle with different data must change nothing
        begin
            logic [255:0] hw;
            logic [15:0]  hf;
            hw = bus_data_n;
            hf = bus_inv_n;
            tx_valid = 1'b0;
            tx_data  = ~tx_data;
            @(negedge clk);
            chk(bus_valid === 1'b0, "R7 bus_valid low", {255'd0, bus_valid}, 256'd0);
            chk(bus_data_n === hw, "R7 bus held", bus_data_n, hw);
            chk(bus_inv_n === hf, "R7 flags held", {240'd0, bus_inv_n}, {240'd0, hf});
        end
        // R7: reference untouched, checked by the next word
        send(256'h0);

        // Random words with occasional idle cycles
        for (int n = 0; n < 40; n++) begin
            send(rnd256());
            if (n % 7 == 3) begin
                tx_valid = 1'b0;
                @(negedge clk);
                chk(bus_valid === 1'b0, "R7 idle", {255'd0, bus_valid}, 256'd0);
            end
        end

        // Alternating extremes
        send({4{64'hFFFF_FFFF_FFFF_FFFF}});
        send({4{64'hAAAA_5555_AAAA_5555}});
        send({64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF});

        // R5: reset mid-run returns the reference to zero
        tx_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        mref = '0;
        last_wire = '1;
        @(negedge clk);
        check_reset();
        send({4{64'hFFFF_FFFF_FFFF_FFFF}});
        chk(bus_inv_n[3:0] === 4'h0, "R5 all lanes invert after reset",
            {252'd0, bus_inv_n[3:0]}, 256'd0);
        chk(bus_data_n === '1, "R5 wire stays high", bus_data_n, '1);

        tx_valid = 1'b0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule